// File: doc/BRIEF.md
# Clock-Following Serial Word Receiver

This block is the receive half of a clocked serial port that runs as a slave. An external master drives the shift clock and a data line. The block brings both into the system clock domain through a short synchronizer chain. On each rising edge of the shift clock it samples one data bit, least significant bit first, into a shift register. Once the configured number of bits has arrived (eight, or nine in wide mode), the word moves into a one-deep holding register and is offered on a valid/ready output.

The holding register is the only buffer. `rx_valid` goes high when a word lands and stays high until a cycle in which `rx_ready` is also high, which consumes the word. The receiver does not wait for the consumer. If another word completes while the held word has not been taken, that new word is dropped and an overrun flag is set. Shifting then stops until software clears the continuous-receive enable, which also clears the flag and restarts the bit count.

An interrupt request follows the valid flag, gated by an enable. It is a plain combinational level, so it can serve as a wake request while the rest of the system is halted.

Top module: `sync_slave_rx`

## Requirements
- R1: Words are received only while `port_en`=1, `sync_mode`=1 and `clk_src_int`=0. In any other combination, shift-clock edges produce no word and the bit count is held at zero.
- R2: Reception runs only while `cont_rx_en`=1. `single_rx_en` has no effect: with `cont_rx_en`=0, a full word of clock edges produces no word, whatever `single_rx_en` is.
- R3: Each rising edge of `sclk_in` samples `sdata_in`, least significant bit first. After eight edges in 8-bit mode, `rx_data` holds the word and `rx_valid` rises. In 8-bit mode, `rx_ninth` reads 0.
- R4: With `nine_bit`=1, a word takes nine edges. The ninth bit received is reported on `rx_ninth` and the first eight bits are reported on `rx_data`.
- R5: `rx_valid` stays high and `rx_data` stays stable until a cycle with `rx_ready`=1. After that cycle, `rx_valid` is low unless a new word has landed.
- R6: `rx_irq` is high exactly when `rx_valid`=1 and `rx_ie`=1.
- R7: A word that completes while `rx_valid`=1 and no handshake occurs in that cycle:
  - is discarded, and the held word is kept;
  - sets `ovr_err`, which stays set while `cont_rx_en`=1;
  - blocks all further shifting.
  Clearing `cont_rx_en` clears `ovr_err`.
- R8: Clearing `cont_rx_en` clears the partial word and the bit count, so the next word starts at bit 0.
- R9: `frame_err` always reads 0, since a clocked word has no stop bit to check.
- R10: After reset, `rx_valid`, `ovr_err`, `frame_err` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | 1 = clocked (synchronous) mode |
| clk_src_int | input | 1 | 1 = internal clock source (master); 0 = slave |
| nine_bit | input | 1 | 1 = nine-bit words |
| cont_rx_en | input | 1 | Continuous-receive enable; clearing it clears errors |
| single_rx_en | input | 1 | Single-receive enable; has no effect in slave mode |
| rx_ie | input | 1 | Receive interrupt enable |
| sclk_in | input | 1 | External shift clock (asynchronous) |
| sdata_in | input | 1 | Serial data line (asynchronous) |
| rx_valid | output | 1 | Holding register holds an unread word |
| rx_ready | input | 1 | Consumer takes the word when high with rx_valid |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_ninth | output | 1 | Received ninth bit (0 in 8-bit mode) |
| frame_err | output | 1 | Framing error status (always 0 here) |
| ovr_err | output | 1 | Overrun error status, sticky |
| rx_irq | output | 1 | Receive interrupt / wake request |

## Verification
The assertions assume the following about the inputs:
- The shift clock is much slower than the system clock, with each high and low phase lasting longer than the synchronizer delay, so every shift-clock edge yields one clean, isolated pulse.
- `sdata_in` is stable across the cycles around each rising edge.
- The mode and width controls change only while `cont_rx_en` is low.

The stimulus holds each shift-clock phase for four system cycles and sets the data bit one phase ahead of the edge. It changes the configuration only between words, with the enable dropped, except in the scenarios where disabling the port is the point of the test.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_BITS = DATA_W + 1;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  typedef struct packed {
    logic              ninth;
    logic [DATA_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic sclk_rise,
  output logic sdata_s
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dat_chain;
  logic              clk_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_chain[0] <= 1'b0;
            dat_chain[0] <= 1'b0;
          end else begin
            clk_chain[0] <= sclk_in;
            dat_chain[0] <= sdata_in;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_chain[g] <= 1'b0;
            dat_chain[g] <= 1'b0;
          end else begin
            clk_chain[g] <= clk_chain[g-1];
            dat_chain[g] <= dat_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_chain[STAGES-1];
  end

  assign sclk_rise = clk_chain[STAGES-1] & ~clk_prev;
  assign sdata_s   = dat_chain[STAGES-1];

  // R3: one sample per shift-clock edge
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import sync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     block,
  input  logic     nine_bit,
  input  logic     bit_rise,
  input  logic     bit_val,
  output logic     word_done,
  output rx_word_t word
);
  logic [MAX_BITS-1:0] shreg, shreg_nxt;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last_idx;
  logic                last_bit;

  assign last_idx = nine_bit ? CNT_W'(MAX_BITS-1) : CNT_W'(DATA_W-1);
  assign last_bit = (cnt >= last_idx);

  always_comb begin
    shreg_nxt = shreg;
    for (int i = 0; i < MAX_BITS; i++)
      if (CNT_W'(i) == cnt) shreg_nxt[i] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      word_done <= 1'b0;
      if (!active) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (bit_rise && !block) begin
        if (last_bit) begin
          shreg      <= '0;
          cnt        <= '0;
          word_done  <= 1'b1;
          word.data  <= shreg_nxt[DATA_W-1:0];
          word.ninth <= nine_bit & shreg_nxt[MAX_BITS-1];
        end else begin
          shreg <= shreg_nxt;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: leaving the enabled state restarts the bit count
  p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  // R4: the counter never passes the widest word
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_BITS-1));
  // R7: a blocked shifter produces no word
  p_block_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> !word_done);
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import sync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cont_rx_en,
  input  logic     word_done,
  input  rx_word_t word,
  input  logic     rx_ready,
  output logic     rx_valid,
  output rx_word_t held,
  output logic     ovr_err
);
  logic take;
  assign take = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      if (!cont_rx_en)                   ovr_err <= 1'b0;
      else if (word_done && rx_valid && !take) ovr_err <= 1'b1;

      if (word_done && (!rx_valid || take)) rx_valid <= 1'b1;
      else if (take)                        rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (word_done && (!rx_valid || take)) held <= word;
  end

  // R3: a word only appears after the shifter completes one
  p_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(word_done));
  // R5: a handshake with no new word empties the register
  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !word_done) |=> !rx_valid);
  // R5: unread data is stable
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !take) |=> $stable(held));
  // R7: overrun is sticky while the enable stays set
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && cont_rx_en) |=> ovr_err);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_src_int,
  input  logic              nine_bit,
  input  logic              cont_rx_en,
  input  logic              single_rx_en,
  input  logic              rx_ie,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ninth,
  output logic              frame_err,
  output logic              ovr_err,
  output logic              rx_irq
);
  logic     sclk_rise, sdata_s, word_done, active, slave_sel;
  rx_word_t word, held;

  // single_rx_en intentionally unused in slave mode
  logic unused_single;
  assign unused_single = single_rx_en;

  assign slave_sel = port_en & sync_mode & ~clk_src_int;
  assign active    = slave_sel & cont_rx_en;

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_rise(sclk_rise), .sdata_s(sdata_s)
  );

  rx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .block(ovr_err),
    .nine_bit(nine_bit), .bit_rise(sclk_rise), .bit_val(sdata_s),
    .word_done(word_done), .word(word)
  );

  rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cont_rx_en(cont_rx_en),
    .word_done(word_done), .word(word), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .held(held), .ovr_err(ovr_err)
  );

  assign rx_data   = held.data;
  assign rx_ninth  = held.ninth;
  assign frame_err = 1'b0;
  assign rx_irq    = rx_valid & rx_ie;
endmodule

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, sync_mode = 0, clk_src_int = 0, nine_bit = 0;
  logic cont_rx_en = 0, single_rx_en = 0, rx_ie = 0;
  logic sclk_in = 0, sdata_in = 0, rx_ready = 0;
  logic rx_valid, rx_ninth, frame_err, ovr_err, rx_irq;
  logic [7:0] rx_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_slave_rx u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_src_int(clk_src_int), .nine_bit(nine_bit), .cont_rx_en(cont_rx_en),
    .single_rx_en(single_rx_en), .rx_ie(rx_ie), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ninth(rx_ninth), .frame_err(frame_err),
    .ovr_err(ovr_err), .rx_irq(rx_irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [8:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sdata_in = v[i];
      wait_n(4);
      sclk_in = 1;
      wait_n(4);
      sclk_in = 0;
    end
    wait_n(6);
  endtask

  task automatic pop();
    rx_ready = 1;
    wait_n(1);
    rx_ready = 0;
    wait_n(1);
  endtask

  task automatic restart();
    cont_rx_en = 0;
    wait_n(2);
    cont_rx_en = 1;
    wait_n(2);
  endtask

  task automatic t_reset();
    check("R10 valid", 16'(rx_valid), 16'h0);
    check("R10 ovr", 16'(ovr_err), 16'h0);
    check("R10 irq", 16'(rx_irq), 16'h0);
    check("R9 frame", 16'(frame_err), 16'h0);
  endtask

  task automatic t_basic();
    rx_ie = 1;
    send_bits(9'h0A5, 8);
    check("R3 valid", 16'(rx_valid), 16'h1);
    check("R3 data", 16'(rx_data), 16'h00A5);
    check("R3 ninth", 16'(rx_ninth), 16'h0);
    check("R6 irq on", 16'(rx_irq), 16'h1);
    rx_ie = 0;
    wait_n(1);
    check("R6 irq gated", 16'(rx_irq), 16'h0);
    wait_n(10);
    check("R5 held", 16'(rx_valid), 16'h1);
    check("R5 data held", 16'(rx_data), 16'h00A5);
    pop();
    check("R5 popped", 16'(rx_valid), 16'h0);
  endtask

  task automatic t_nine();
    cont_rx_en = 0; nine_bit = 1; wait_n(2); cont_rx_en = 1; wait_n(2);
    send_bits(9'h13C, 8);
    check("R4 not yet", 16'(rx_valid), 16'h0);
    send_bits(9'h001, 1);
    check("R4 valid", 16'(rx_valid), 16'h1);
    check("R4 data", 16'(rx_data), 16'h003C);
    check("R4 ninth", 16'(rx_ninth), 16'h1);
    pop();
    cont_rx_en = 0; nine_bit = 0; wait_n(2); cont_rx_en = 1; wait_n(2);
  endtask

  task automatic t_single_ignored();
    cont_rx_en = 0; single_rx_en = 1; wait_n(2);
    send_bits(9'h0FF, 8);
    check("R2 no word", 16'(rx_valid), 16'h0);
    single_rx_en = 0; cont_rx_en = 1; wait_n(2);
    send_bits(9'h042, 8);
    check("R2 enabled data", 16'(rx_data), 16'h0042);
    pop();
  endtask

  task automatic t_master_blocked();
    clk_src_int = 1; wait_n(2);
    send_bits(9'h0FF, 8);
    check("R1 master no word", 16'(rx_valid), 16'h0);
    clk_src_int = 0; port_en = 0; wait_n(2);
    send_bits(9'h0FF, 8);
    check("R1 disabled no word", 16'(rx_valid), 16'h0);
    port_en = 1; wait_n(2);
    send_bits(9'h081, 8);
    check("R1 slave data", 16'(rx_data), 16'h0081);
    pop();
  endtask

  task automatic t_overrun();
    send_bits(9'h011, 8);
    send_bits(9'h022, 8);
    check("R7 ovr set", 16'(ovr_err), 16'h1);
    check("R7 kept old", 16'(rx_data), 16'h0011);
    send_bits(9'h033, 8);
    pop();
    check("R7 blocked", 16'(rx_valid), 16'h0);
    send_bits(9'h044, 8);
    check("R7 still blocked", 16'(rx_valid), 16'h0);
    check("R7 sticky", 16'(ovr_err), 16'h1);
    cont_rx_en = 0; wait_n(2);
    check("R7 cleared", 16'(ovr_err), 16'h0);
    cont_rx_en = 1; wait_n(2);
    send_bits(9'h066, 8);
    check("R7 resumes", 16'(rx_data), 16'h0066);
    pop();
  endtask

  task automatic t_partial();
    send_bits(9'h007, 3);
    restart();
    send_bits(9'h05A, 8);
    check("R8 valid", 16'(rx_valid), 16'h1);
    check("R8 data", 16'(rx_data), 16'h005A);
    check("R9 frame", 16'(frame_err), 16'h0);
    pop();
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1;
    port_en = 1; sync_mode = 1; clk_src_int = 0; cont_rx_en = 1;
    wait_n(3);
    t_basic();
    t_nine();
    t_single_ignored();
    t_master_blocked();
    t_overrun();
    t_partial();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule